// File: doc/BRIEF.md
# Constant Divide-by-27 Pipeline

This block divides an unsigned 32-bit dividend by the fixed value 27 (one base-27 digit, 3^3) and returns the quotient and the remainder. It is the inner step of a byte-to-tryte radix conversion, where a wide integer is repeatedly split into base-27 digits. No iterative divider is used. The dividend is multiplied by a 43-bit-fraction fixed-point reciprocal of 27, equal to ceil(2^43 / 27). The integer part of that product is the quotient. The quotient is then multiplied back by 27, and the result is subtracted from the dividend to give the remainder.

The block is a four-stage pipeline with valid/ready streams on both sides. The input handshake is `in_valid`/`in_ready`. The output handshake is `out_valid`/`out_ready`, and a result moves when both are high on a rising edge. Back-pressure stalls the whole pipeline at once, so `in_ready` depends combinationally on `out_ready`. A stalled result stays stable on the output until it is taken. If the consumer keeps `out_ready` high, the block accepts a new dividend every cycle.

Top module: `div27_pipe`

## Requirements
- R1: For every 32-bit unsigned dividend D, `out_quot` equals floor(D / 27), given as a 28-bit unsigned value.
- R2: `out_rem` equals D mod 27, given as a 5-bit unsigned value that is always in 0..26.
- R3: With `out_ready` held high, a dividend accepted on a rising edge shows up with `out_valid` high after the fourth rising edge, counting the accepting edge as the first. `out_valid` stays low after the first three of those edges.
- R4: While `out_ready` is high, `in_ready` is high, so one dividend can be accepted every cycle.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next edge `out_valid` stays high and `out_quot`/`out_rem` do not change.
- R6: Results leave in the order their dividends were accepted. No result is lost or duplicated.
- R7: Synchronous active-high `rst` clears every stage's valid flag. After reset, `out_valid` is low and `in_ready` is high.
- R8: A cycle with `in_valid` low produces no result, whatever value is on `in_dividend`.
- R9: The dividends 0, 26, 27, 28 and 2^32-1 give exact results. For example, 2^32-1 gives quotient 159072862 and remainder 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Dividend on `in_dividend` is offered |
| in_ready | output | 1 | Block takes the dividend on this edge |
| in_dividend | input | 32 | Unsigned dividend |
| out_valid | output | 1 | Quotient and remainder are valid |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_quot | output | 28 | floor(dividend / 27) |
| out_rem | output | 5 | dividend mod 27 |

## Verification
The assertions assume that the consumer drives `out_ready` to a known level on every cycle outside reset. They also assume the dividend is any 32-bit value, which is the whole range where the reciprocal is exact. The stimulus draws dividends from $urandom with a fixed seed, so it covers the full 32-bit range. It biases some of them toward multiples of 27 and their neighbours, and it adds the extreme values as directed cases. It toggles `in_valid` and `out_ready` at random, so the back-pressure hold rule is exercised many times without ever leaving the assumed input set.

// File: rtl/div27_pkg.sv
package div27_pkg;
  localparam int unsigned DIVIDEND_W = 32;
  localparam int unsigned DIVISOR    = 27;
  localparam int unsigned RECIP_FRAC = 43;

  // Rounded-up fixed-point reciprocal: ceil(2^frac / div)
  function automatic logic [63:0] recip_of(input int unsigned div, input int unsigned frac);
    logic [63:0] one;
    one = 64'd1 << frac;
    return (one + 64'(div) - 64'd1) / 64'(div);
  endfunction
endpackage

// File: rtl/d27_quot_stage.sv
module d27_quot_stage #(
  parameter int unsigned DW   = 32,
  parameter int unsigned DIV  = 27,
  parameter int unsigned FRAC = 43,
  localparam int unsigned QW  = DW - $clog2(DIV) + 1,
  localparam int unsigned PW  = FRAC + QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  output logic          v_o,
  output logic [DW-1:0] d_o,
  output logic [QW-1:0] q_o
);
  import div27_pkg::*;
  localparam logic [PW-1:0] RECIP_W = PW'(recip_of(DIV, FRAC));

  logic [QW-1:0] q_c;
  assign q_c = QW'((PW'(d_i) * RECIP_W) >> FRAC);

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (en) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      d_o <= d_i;
      q_o <= q_c;
    end
  end

  // quotient never exceeds the dividend (R1)
  p_quot_le_r1: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (DW'(q_o) <= d_o));
endmodule

// File: rtl/d27_back_stage.sv
module d27_back_stage #(
  parameter int unsigned DW  = 32,
  parameter int unsigned DIV = 27,
  localparam int unsigned QW = DW - $clog2(DIV) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  input  logic [QW-1:0] q_i,
  output logic          v_o,
  output logic [DW-1:0] d_o,
  output logic [QW-1:0] q_o,
  output logic [DW-1:0] qd_o
);
  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (en) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      d_o  <= d_i;
      q_o  <= q_i;
      qd_o <= DW'(q_i) * DW'(DIV);
    end
  end

  // back product never overshoots the dividend (R2)
  p_back_le_r2: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (qd_o <= d_o));
endmodule

// File: rtl/d27_rem_stage.sv
module d27_rem_stage #(
  parameter int unsigned DW  = 32,
  parameter int unsigned DIV = 27,
  localparam int unsigned QW = DW - $clog2(DIV) + 1,
  localparam int unsigned RW = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  input  logic [QW-1:0] q_i,
  input  logic [DW-1:0] qd_i,
  output logic          v_o,
  output logic [QW-1:0] q_o,
  output logic [RW-1:0] r_o
);
  logic [DW-1:0] d_q;
  logic [DW-1:0] diff;
  assign diff = d_i - qd_i;

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (en) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      d_q <= d_i;
      q_o <= q_i;
      r_o <= RW'(diff);
    end
  end

  p_rem_range_r2: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (DW'(r_o) < DW'(DIV)));

  p_recon_r1: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (DW'(q_o) * DW'(DIV) + DW'(r_o) == d_q));
endmodule

// File: rtl/div27_pipe.sv
module div27_pipe #(
  parameter int unsigned DW   = div27_pkg::DIVIDEND_W,
  parameter int unsigned DIV  = div27_pkg::DIVISOR,
  parameter int unsigned FRAC = div27_pkg::RECIP_FRAC,
  localparam int unsigned QW  = DW - $clog2(DIV) + 1,
  localparam int unsigned RW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [QW-1:0] out_quot,
  output logic [RW-1:0] out_rem
);
  logic          adv;
  logic          v1, v2, v3;
  logic [DW-1:0] d1, d2, d3;
  logic [QW-1:0] q2, q3;
  logic [DW-1:0] qd3;

  // whole pipeline advances unless a finished result is held back
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else if (adv) v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) d1 <= in_dividend;
  end

  d27_quot_stage #(.DW(DW), .DIV(DIV), .FRAC(FRAC)) u_quot (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(v1), .d_i(d1),
    .v_o(v2), .d_o(d2), .q_o(q2)
  );

  d27_back_stage #(.DW(DW), .DIV(DIV)) u_back (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(v2), .d_i(d2), .q_i(q2),
    .v_o(v3), .d_o(d3), .q_o(q3), .qd_o(qd3)
  );

  d27_rem_stage #(.DW(DW), .DIV(DIV)) u_rem (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(v3), .d_i(d3), .q_i(q3), .qd_i(qd3),
    .v_o(out_valid), .q_o(out_quot), .r_o(out_rem)
  );

  p_ready_r4: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quot) && $stable(out_rem)));

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_div27_pipe.sv
module sim_div27_pipe;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_dividend;
  logic [27:0] out_quot;
  logic [4:0]  out_rem;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  logic [31:0] sb[$];

  always #5 clk = ~clk;

  div27_pipe u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .out_valid(out_valid), .out_ready(out_ready),
    .out_quot(out_quot), .out_rem(out_rem));

  function automatic logic [27:0] exp_q(input logic [31:0] d); return 28'(d / 32'd27); endfunction
  function automatic logic [4:0]  exp_r(input logic [31:0] d); return 5'(d % 32'd27); endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, settle, then judge the handshakes the next posedge will perform
  logic        prev_hold = 0;
  logic [27:0] prev_q;
  logic [4:0]  prev_r;
  task automatic step(input bit iv, input logic [31:0] d, input bit ordy);
    logic [31:0] h;
    @(negedge clk);
    if (prev_hold) begin
      chk(out_valid == 1'b1, "R5 valid held", out_valid, 1);
      chk(out_quot == prev_q && out_rem == prev_r, "R5 data held", out_quot, prev_q);
    end
    in_valid = iv; in_dividend = d; out_ready = ordy;
    #1;
    if (ordy) chk(in_ready == 1'b1, "R4 ready", in_ready, 1);
    if (out_valid && !ordy) chk(in_ready == 1'b0, "R5 stall", in_ready, 0);
    if (out_valid && ordy) begin
      if (sb.size() == 0) chk(0, "R6 extra result", out_quot, 0);
      else begin
        h = sb.pop_front();
        chk(out_quot == exp_q(h), "R1 quotient", out_quot, exp_q(h));
        chk(out_rem == exp_r(h), "R2 remainder", out_rem, exp_r(h));
      end
    end
    if (iv && in_ready) sb.push_back(d);
    prev_hold = out_valid && !ordy;
    prev_q = out_quot; prev_r = out_rem;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5] = '{32'd0, 32'd26, 32'd27, 32'd28, 32'hFFFF_FFFF};
    logic [31:0] d;
    int seen;
    void'($urandom(32'd2718));
    rst = 1; in_valid = 0; out_ready = 0; in_dividend = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid in reset", out_valid, 0);
    @(negedge clk); rst = 0; #1;
    chk(out_valid == 1'b0, "R7 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);

    // R8: junk data without valid never yields output
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step(0, $urandom, 1);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R8 no result from idle", seen, 0);

    // R3: latency of one isolated dividend
    step(1, 32'd1000, 1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      in_valid = 0; out_ready = 1; #1;
      if (k < 4) chk(out_valid == 1'b0, "R3 early", out_valid, 0);
      else begin
        chk(out_valid == 1'b1, "R3 arrival", out_valid, 1);
        d = sb.pop_front();
        chk(out_quot == exp_q(d) && out_rem == exp_r(d), "R3 value", out_quot, exp_q(d));
      end
    end

    // R9: corners, back to back
    for (int i = 0; i < 5; i++) step(1, corner[i], 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    chk(exp_q(32'hFFFF_FFFF) == 28'd159072862 && exp_r(32'hFFFF_FFFF) == 5'd21,
        "R9 model max", exp_q(32'hFFFF_FFFF), 159072862);

    // random traffic with back-pressure (R1, R2, R4, R5, R6)
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 4)
        0: d = $urandom;
        1: d = ($urandom % 32'd159072863) * 32'd27 + ($urandom % 3) - 1;
        2: d = 32'hFFFF_FFFF - ($urandom % 64);
        default: d = $urandom % 1024;
      endcase
      step(($urandom % 4) != 0, d, ($urandom % 10) < 7);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    chk(sb.size() == 0, "R6 nothing lost", sb.size(), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule